// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Tree

This block produces the clock enables for a processor core, a double-rate memory bus, the AHB and APB buses, two dedicated AHB clients (an image codec and a security engine) and a set of special peripherals. Every output is a one-cycle enable pulse in the domain of a single fast clock. Real clock muxes and gating cells are not part of it. Three PLL outputs and two reference inputs arrive as tick pulses on the same fast clock. At the end of reset, a strap pin picks one of the two references. After that, each of the three clock groups takes either that reference or its own PLL.

Software programs the block through a small register port. The registers hold a three-bit source selection, six four-bit divider fields and three gate masks with one bit per peripheral. The core divider counts ticks from group 0. The memory-bus divider counts ticks from group 1. The AHB, APB, codec and security dividers all count memory-bus pulses.

A divider change takes effect only when the divider that is running reaches the end of its period. Any divider write that would leave the APB clock out of step with an AHB-side clock is refused, and a sticky error bit records the refusal.

Top module: `clk_div_tree`

## Requirements
- R1: Source bit g of the source register (offset 0, bits 2:0; group 0 = core, 1 = memory bus, 2 = special) set to 0 routes the reference tick to group g. Set to 1, it routes PLL tick g instead.
- R2: The reference is captured from `refModePin` while `rstN` is low: 0 selects `xtalTick` and 1 selects `extTick`. The captured value reads back at status bit 1, and later changes on the pin have no effect.
- R3: A divider field value N gives one enable pulse for every N+1 source ticks. The pulse coincides with the tick that ends the period, and N = 0 passes every tick through.
- R4: A value written to a divider field is loaded only at the terminal count of the period in progress, so no period is ever shortened or stretched by a write.
- R5: The divider register (offset 1) holds these fields, each 4 bits wide starting at the bit given: core at bit 0, memory bus at bit 4, AHB at bit 8, APB at bit 12, codec at bit 16, security at bit 20. The core divider counts group-0 ticks and the memory-bus divider counts group-1 ticks. The AHB, APB, codec and security dividers count memory-bus pulses.
- R6: A divider write is accepted only if, for each of the AHB, codec and security fields, the APB division factor is an integer multiple of that field's factor, and the quotient is 1 or even.
- R7: A divider write that breaks R6 leaves every divider field unchanged and sets the sticky error at status bit 0 (offset 5). Writing status with bit 0 set clears the error, and nothing else clears it.
- R8: The gate masks are AHB at offset 2, APB at offset 3 and special at offset 4. Output bit i equals the matching enable ANDed with mask bit i. For the special mask, the matching enable is the undivided group-2 tick, and a cleared bit stops that output.
- R9: After reset the source bits and all divider fields are 0, every gate bit is 1 and the error bit is 0.
- R10: Reads return each register zero-extended at its offset. Offsets 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that every enable is referred to |
| rstN | input | 1 | Active-low reset |
| refModePin | input | 1 | Reference strap, captured during reset |
| xtalTick | input | 1 | Crystal reference tick |
| extTick | input | 1 | External reference tick |
| pllTick | input | 3 | PLL ticks for core, memory bus and special groups |
| regAddr | input | 3 | Register offset for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| cpuEn | output | 1 | Core clock enable |
| memEn | output | 1 | Double-rate memory bus enable |
| ahbEn | output | 1 | AHB bus enable |
| apbEn | output | 1 | APB bus enable |
| codecEn | output | 1 | Image codec clock enable |
| secEn | output | 1 | Security engine clock enable |
| ahbClkEn | output | 8 | Gated AHB enables per peripheral |
| apbClkEn | output | 8 | Gated APB enables per peripheral |
| spcClkEn | output | 4 | Gated special-clock enables per peripheral |

## Verification
The assertions check several properties on every cycle. Each divider count stays within its limit and the limit moves only at a terminal tick. The held divider set always satisfies the APB ratio rule, and a refused write leaves the fields untouched and raises the error. The error persists until it is cleared, and the captured reference never changes outside reset. Pulse spacing across a divider reprogram, the routing of each source selection and the effect of the gate masks can only be shown by the bench's scenarios. The bench compares every output against a cycle model under random ticks and register traffic.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;
  localparam int DIV_W   = 4;
  localparam int NUM_DIV = 6;
  localparam int NUM_GRP = 3;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int DIV_BITS = NUM_DIV * DIV_W;

  localparam int DIV_CPU   = 0;
  localparam int DIV_MEM   = 1;
  localparam int DIV_AHB   = 2;
  localparam int DIV_APB   = 3;
  localparam int DIV_CODEC = 4;
  localparam int DIV_SEC   = 5;

  localparam logic [ADDR_W-1:0] REG_SRC  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_AHBG = 3'd2;
  localparam logic [ADDR_W-1:0] REG_APBG = 3'd3;
  localparam logic [ADDR_W-1:0] REG_SPCG = 3'd4;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd5;

  typedef logic [NUM_DIV-1:0][DIV_W-1:0] divSet_t;

  // Configuration handed from control to datapath.
  typedef struct packed {
    logic [NUM_GRP-1:0] srcSel;
    divSet_t            divSel;
  } treeCfg_t;

  // APB factor must be a multiple of the client factor with quotient 1 or even.
  function automatic logic ratioOk(logic [DIV_W-1:0] apbField, logic [DIV_W-1:0] cliField);
    int unsigned pf;
    int unsigned cf;
    int unsigned q;
    pf = int'(apbField) + 1;
    cf = int'(cliField) + 1;
    if ((pf % cf) != 0) return 1'b0;
    q = pf / cf;
    return (q == 1) || ((q % 2) == 0);
  endfunction

  function automatic logic divRuleOk(divSet_t d);
    return ratioOk(d[DIV_APB], d[DIV_AHB]) &&
           ratioOk(d[DIV_APB], d[DIV_CODEC]) &&
           ratioOk(d[DIV_APB], d[DIV_SEC]);
  endfunction
endpackage

// File: rtl/clk_tree_div_cell.sv
module clk_tree_div_cell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic [W-1:0] nextLim,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         atEnd;

  assign atEnd = (cnt == lim);
  assign pulse = tick && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      lim <= '0;
    end else if (tick) begin
      if (atEnd) begin
        cnt <= '0;
        lim <= nextLim;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: count never passes the active limit
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN) cnt <= lim)
    else $error("R3 divider count beyond limit");

  // R3: without a source tick the count holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN) !tick |=> $stable(cnt))
    else $error("R3 divider count moved without tick");

  // R4: limit changes only at a terminal tick
  a_r4_lim_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !(tick && cnt == lim) |=> $stable(lim))
    else $error("R4 divider limit changed mid-period");
endmodule

// File: rtl/clk_tree_ctrl.sv
module clk_tree_ctrl
  import clk_tree_pkg::*;
#(
  parameter int AHB_N = 8,
  parameter int APB_N = 8,
  parameter int SPC_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refModePin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output treeCfg_t          cfg,
  output logic [AHB_N-1:0]  ahbGate,
  output logic [APB_N-1:0]  apbGate,
  output logic [SPC_N-1:0]  spcGate,
  output logic              refSel
);
  logic [NUM_GRP-1:0] srcReg;
  divSet_t            divReg;
  divSet_t            candDiv;
  logic               candOk;
  logic               errFlag;
  logic               wrSrc, wrDiv, wrAhb, wrApb, wrSpc, wrStat;
  logic               unusedWrBits;

  assign candDiv      = divSet_t'(regWrData[DIV_BITS-1:0]);
  assign candOk       = divRuleOk(candDiv);
  assign unusedWrBits = ^regWrData[DATA_W-1:DIV_BITS];

  assign wrSrc  = regWrEn && (regAddr == REG_SRC);
  assign wrDiv  = regWrEn && (regAddr == REG_DIV);
  assign wrAhb  = regWrEn && (regAddr == REG_AHBG);
  assign wrApb  = regWrEn && (regAddr == REG_APBG);
  assign wrSpc  = regWrEn && (regAddr == REG_SPCG);
  assign wrStat = regWrEn && (regAddr == REG_STAT);

  // Strap capture while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) refSel <= refModePin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg  <= '0;
      divReg  <= '0;
      ahbGate <= '1;
      apbGate <= '1;
      spcGate <= '1;
      errFlag <= 1'b0;
    end else begin
      if (wrSrc) srcReg <= regWrData[NUM_GRP-1:0];
      if (wrAhb) ahbGate <= regWrData[AHB_N-1:0];
      if (wrApb) apbGate <= regWrData[APB_N-1:0];
      if (wrSpc) spcGate <= regWrData[SPC_N-1:0];
      if (wrDiv) begin
        if (candOk) divReg  <= candDiv;
        else        errFlag <= 1'b1;
      end
      if (wrStat && regWrData[0]) errFlag <= 1'b0;
    end
  end

  assign cfg.srcSel = srcReg;
  assign cfg.divSel = divReg;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_SRC:  regRdData[NUM_GRP-1:0]  = srcReg;
      REG_DIV:  regRdData[DIV_BITS-1:0] = divReg;
      REG_AHBG: regRdData[AHB_N-1:0]    = ahbGate;
      REG_APBG: regRdData[APB_N-1:0]    = apbGate;
      REG_SPCG: regRdData[SPC_N-1:0]    = spcGate;
      REG_STAT: regRdData[1:0]          = {refSel, errFlag};
      default:  regRdData = '0;
    endcase
  end

  // R6: the held divider set always obeys the APB ratio rule
  a_r6_rule_held: assert property (@(posedge clk) disable iff (!rstN) divRuleOk(divReg))
    else $error("R6 divider set violates ratio rule");

  // R7: refused write keeps fields and raises the error
  a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (wrDiv && !divRuleOk(divSet_t'(regWrData[DIV_BITS-1:0]))) |=> ($stable(divReg) && errFlag))
    else $error("R7 refused divider write altered state");

  // R7: error is sticky until cleared through status
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(regWrEn && regAddr == REG_STAT && regWrData[0])) |=> errFlag)
    else $error("R7 error flag dropped without clear");

  // R2: captured reference holds while out of reset
  a_r2_ref_held: assert property (@(posedge clk) disable iff (!rstN) rstN |=> $stable(refSel))
    else $error("R2 reference select changed after reset");
endmodule

// File: rtl/clk_tree_datapath.sv
module clk_tree_datapath
  import clk_tree_pkg::*;
#(
  parameter int AHB_N = 8,
  parameter int APB_N = 8,
  parameter int SPC_N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refSel,
  input  logic               xtalTick,
  input  logic               extTick,
  input  logic [NUM_GRP-1:0] pllTick,
  input  treeCfg_t           cfg,
  input  logic [AHB_N-1:0]   ahbGate,
  input  logic [APB_N-1:0]   apbGate,
  input  logic [SPC_N-1:0]   spcGate,
  output logic [NUM_DIV-1:0] divEn,
  output logic [AHB_N-1:0]   ahbClkEn,
  output logic [APB_N-1:0]   apbClkEn,
  output logic [SPC_N-1:0]   spcClkEn
);
  logic                       refTick;
  logic [NUM_GRP-1:0]         grpTick;
  logic                       cpuPulse;
  logic                       memPulse;
  logic [NUM_DIV-1:DIV_AHB]   busPulse;

  assign refTick = refSel ? extTick : xtalTick;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGroup
    assign grpTick[g] = cfg.srcSel[g] ? pllTick[g] : refTick;
  end

  clk_tree_div_cell #(.W(DIV_W)) uCpuDiv (
    .clk(clk), .rstN(rstN), .tick(grpTick[0]),
    .nextLim(cfg.divSel[DIV_CPU]), .pulse(cpuPulse)
  );

  clk_tree_div_cell #(.W(DIV_W)) uMemDiv (
    .clk(clk), .rstN(rstN), .tick(grpTick[1]),
    .nextLim(cfg.divSel[DIV_MEM]), .pulse(memPulse)
  );

  // AHB, APB and the two AHB clients all count memory-bus pulses.
  for (genvar i = DIV_AHB; i < NUM_DIV; i++) begin : gBusDiv
    clk_tree_div_cell #(.W(DIV_W)) uCell (
      .clk(clk), .rstN(rstN), .tick(memPulse),
      .nextLim(cfg.divSel[i]), .pulse(busPulse[i])
    );
  end

  assign divEn    = {busPulse, memPulse, cpuPulse};
  assign ahbClkEn = {AHB_N{busPulse[DIV_AHB]}} & ahbGate;
  assign apbClkEn = {APB_N{busPulse[DIV_APB]}} & apbGate;
  assign spcClkEn = {SPC_N{grpTick[2]}} & spcGate;

  // R5: a bus-side pulse needs a memory-bus pulse in the same cycle
  a_r5_bus_follows_mem: assert property (@(posedge clk) disable iff (!rstN)
    (|busPulse) |-> memPulse)
    else $error("R5 bus enable without memory-bus pulse");
endmodule

// File: rtl/clk_div_tree.sv
module clk_div_tree
  import clk_tree_pkg::*;
#(
  parameter int AHB_N = 8,
  parameter int APB_N = 8,
  parameter int SPC_N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refModePin,
  input  logic               xtalTick,
  input  logic               extTick,
  input  logic [NUM_GRP-1:0] pllTick,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               cpuEn,
  output logic               memEn,
  output logic               ahbEn,
  output logic               apbEn,
  output logic               codecEn,
  output logic               secEn,
  output logic [AHB_N-1:0]   ahbClkEn,
  output logic [APB_N-1:0]   apbClkEn,
  output logic [SPC_N-1:0]   spcClkEn
);
  treeCfg_t           cfg;
  logic [AHB_N-1:0]   ahbGate;
  logic [APB_N-1:0]   apbGate;
  logic [SPC_N-1:0]   spcGate;
  logic               refSel;
  logic [NUM_DIV-1:0] divEn;

  clk_tree_ctrl #(.AHB_N(AHB_N), .APB_N(APB_N), .SPC_N(SPC_N)) uCtrl (
    .clk(clk), .rstN(rstN), .refModePin(refModePin),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cfg(cfg),
    .ahbGate(ahbGate), .apbGate(apbGate), .spcGate(spcGate), .refSel(refSel)
  );

  clk_tree_datapath #(.AHB_N(AHB_N), .APB_N(APB_N), .SPC_N(SPC_N)) uPath (
    .clk(clk), .rstN(rstN), .refSel(refSel),
    .xtalTick(xtalTick), .extTick(extTick), .pllTick(pllTick), .cfg(cfg),
    .ahbGate(ahbGate), .apbGate(apbGate), .spcGate(spcGate),
    .divEn(divEn), .ahbClkEn(ahbClkEn), .apbClkEn(apbClkEn), .spcClkEn(spcClkEn)
  );

  assign cpuEn   = divEn[DIV_CPU];
  assign memEn   = divEn[DIV_MEM];
  assign ahbEn   = divEn[DIV_AHB];
  assign apbEn   = divEn[DIV_APB];
  assign codecEn = divEn[DIV_CODEC];
  assign secEn   = divEn[DIV_SEC];
endmodule

// File: tb/clk_div_tree_test.sv
module clk_div_tree_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        refModePin;
  logic        xtalTick, extTick;
  logic [2:0]  pllTick;
  logic [2:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        cpuEn, memEn, ahbEn, apbEn, codecEn, secEn;
  logic [7:0]  ahbClkEn, apbClkEn;
  logic [3:0]  spcClkEn;

  int compared = 0;
  int mismatched = 0;

  // bench model state
  int         mCnt[6];
  int         mLim[6];
  int         mDiv[6];
  logic [2:0] mSrc;
  logic [7:0] mAhbG, mApbG;
  logic [3:0] mSpcG;
  logic       mErr, mRef;

  always #5 clk = ~clk;

  clk_div_tree uut (
    .clk(clk), .rstN(rstN), .refModePin(refModePin),
    .xtalTick(xtalTick), .extTick(extTick), .pllTick(pllTick),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cpuEn(cpuEn), .memEn(memEn), .ahbEn(ahbEn), .apbEn(apbEn),
    .codecEn(codecEn), .secEn(secEn),
    .ahbClkEn(ahbClkEn), .apbClkEn(apbClkEn), .spcClkEn(spcClkEn)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit okRatio(int p, int f);
    int pf = p + 1;
    int cf = f + 1;
    int q;
    if ((pf % cf) != 0) return 1'b0;
    q = pf / cf;
    return (q == 1) || ((q % 2) == 0);
  endfunction

  function automatic logic [31:0] packDiv();
    logic [31:0] v = '0;
    for (int i = 0; i < 6; i++) v[4*i +: 4] = mDiv[i][3:0];
    return v;
  endfunction

  function automatic logic [31:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return {29'd0, mSrc};
      3'd1: return packDiv();
      3'd2: return {24'd0, mAhbG};
      3'd3: return {24'd0, mApbG};
      3'd4: return {28'd0, mSpcG};
      3'd5: return {30'd0, mRef, mErr};
      default: return 32'd0;
    endcase
  endfunction

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0; refModePin = pin;
    xtalTick = 0; extTick = 0; pllTick = 0;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin mCnt[i] = 0; mLim[i] = 0; mDiv[i] = 0; end
    mSrc = 0; mAhbG = '1; mApbG = '1; mSpcG = '1; mErr = 0; mRef = pin;
  endtask

  // One clock: drive, compare against model before the edge, then advance model.
  task automatic cycle(input logic xt, input logic ex, input logic [2:0] pl,
                       input logic we, input logic [2:0] ad, input logic [31:0] wd);
    logic       rt;
    logic [2:0] g;
    logic [5:0] e;
    logic [5:0] tk;
    logic [25:0] expV, actV;
    int f[6];
    bit ok;
    @(negedge clk);
    xtalTick = xt; extTick = ex; pllTick = pl;
    regWrEn = we; regAddr = ad; regWrData = wd;
    #2;
    rt = mRef ? ex : xt;
    for (int k = 0; k < 3; k++) g[k] = mSrc[k] ? pl[k] : rt;
    tk[0] = g[0]; tk[1] = g[1];
    e[0] = g[0] && (mCnt[0] == mLim[0]);
    e[1] = g[1] && (mCnt[1] == mLim[1]);
    for (int i = 2; i < 6; i++) begin
      tk[i] = e[1];
      e[i] = e[1] && (mCnt[i] == mLim[i]);
    end
    expV = {e[0], e[1], e[2], e[3], e[4], e[5],
            {8{e[2]}} & mAhbG, {8{e[3]}} & mApbG, {4{g[2]}} & mSpcG};
    actV = {cpuEn, memEn, ahbEn, apbEn, codecEn, secEn, ahbClkEn, apbClkEn, spcClkEn};
    chk(actV === expV, "R1 R3 R5 R8 enables", {6'd0, actV}, {6'd0, expV});
    chk(regRdData === modelRead(ad), "R10 readback", regRdData, modelRead(ad));
    for (int i = 0; i < 6; i++) begin
      if (tk[i]) begin
        if (mCnt[i] == mLim[i]) begin mCnt[i] = 0; mLim[i] = mDiv[i]; end
        else mCnt[i]++;
      end
    end
    if (we) begin
      case (ad)
        3'd0: mSrc = wd[2:0];
        3'd1: begin
          for (int i = 0; i < 6; i++) f[i] = int'(wd[4*i +: 4]);
          ok = okRatio(f[3], f[2]) && okRatio(f[3], f[4]) && okRatio(f[3], f[5]);
          if (ok) for (int i = 0; i < 6; i++) mDiv[i] = f[i];
          else mErr = 1'b1;
        end
        3'd2: mAhbG = wd[7:0];
        3'd3: mApbG = wd[7:0];
        3'd4: mSpcG = wd[3:0];
        3'd5: if (wd[0]) mErr = 1'b0;
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'd20240611));
    doReset(1'b0);

    // R9 reset values
    cycle(0, 0, 0, 0, 3'd0, 0); chk(regRdData == 32'h0, "R9 source reset", regRdData, 32'h0);
    cycle(0, 0, 0, 0, 3'd1, 0); chk(regRdData == 32'h0, "R9 divider reset", regRdData, 32'h0);
    cycle(0, 0, 0, 0, 3'd2, 0); chk(regRdData == 32'hFF, "R9 ahb gate reset", regRdData, 32'hFF);
    cycle(0, 0, 0, 0, 3'd4, 0); chk(regRdData == 32'hF, "R9 special gate reset", regRdData, 32'hF);
    cycle(0, 0, 0, 0, 3'd5, 0); chk(regRdData == 32'h0, "R9 R2 status reset", regRdData, 32'h0);
    cycle(0, 0, 0, 0, 3'd7, 0); chk(regRdData == 32'h0, "R10 unmapped offset", regRdData, 32'h0);

    // R8 gating
    cycle(0, 0, 0, 1, 3'd2, 32'h05);
    cycle(1, 0, 0, 0, 3'd0, 0);
    chk(ahbClkEn == 8'h05, "R8 ahb gate mask", {24'd0, ahbClkEn}, 32'h05);
    chk(apbClkEn == 8'hFF, "R8 apb all enabled", {24'd0, apbClkEn}, 32'hFF);
    cycle(0, 0, 0, 1, 3'd4, 32'h0);
    cycle(1, 0, 0, 0, 3'd0, 0);
    chk(spcClkEn == 4'h0, "R8 special cleared", {28'd0, spcClkEn}, 32'h0);

    // R1 source select
    cycle(1, 0, 0, 0, 3'd0, 0); chk(cpuEn == 1'b1, "R1 bypass reference", {31'd0, cpuEn}, 1);
    cycle(0, 0, 0, 1, 3'd0, 32'h1);
    cycle(1, 0, 3'b000, 0, 3'd0, 0); chk(cpuEn == 1'b0, "R1 pll selected ignores ref", {31'd0, cpuEn}, 0);
    cycle(0, 0, 3'b001, 0, 3'd0, 0); chk(cpuEn == 1'b1, "R1 pll tick passes", {31'd0, cpuEn}, 1);

    // R2 pin changes after reset are ignored
    refModePin = 1'b1;
    cycle(0, 0, 0, 0, 3'd5, 0); chk(regRdData[1] == 1'b0, "R2 strap held", regRdData, 32'h0);

    // R6 / R7 ratio rule
    cycle(0, 0, 0, 1, 3'd1, (32'd1 << 8) | (32'd2 << 12));
    cycle(0, 0, 0, 0, 3'd1, 0); chk(regRdData == 32'h0, "R7 refused write keeps fields", regRdData, 32'h0);
    cycle(0, 0, 0, 0, 3'd5, 0); chk(regRdData[0] == 1'b1, "R7 error set", regRdData, 32'h1);
    cycle(0, 0, 0, 1, 3'd5, 32'h1);
    cycle(0, 0, 0, 0, 3'd5, 0); chk(regRdData[0] == 1'b0, "R7 error cleared", regRdData, 32'h0);
    cycle(0, 0, 0, 1, 3'd1, (32'd1 << 8) | (32'd3 << 12));
    cycle(0, 0, 0, 0, 3'd1, 0); chk(regRdData == 32'h3100, "R6 even ratio accepted", regRdData, 32'h3100);
    cycle(0, 0, 0, 1, 3'd1, (32'd1 << 8) | (32'd5 << 12));
    cycle(0, 0, 0, 0, 3'd1, 0); chk(regRdData == 32'h3100, "R6 ratio three refused", regRdData, 32'h3100);

    // R3 / R4 divider timing
    doReset(1'b0);
    cycle(0, 0, 0, 1, 3'd1, 32'h3);
    pulses = 0;
    for (int i = 0; i < 9; i++) begin cycle(1, 0, 0, 0, 3'd0, 0); pulses += cpuEn; end
    chk(pulses == 3, "R4 reload at terminal count", pulses, 3);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin cycle(1, 0, 0, 0, 3'd0, 0); pulses += cpuEn; end
    chk(pulses == 2, "R3 divide by four", pulses, 2);

    // R5 bus chain with memory divider
    cycle(0, 0, 0, 1, 3'd1, 32'h00003110);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin cycle(1, 0, 0, 0, 3'd0, 0); pulses += apbEn; end
    chk(pulses >= 4 && pulses <= 6, "R5 apb from memory pulses", pulses, 5);

    // R2 external reference
    doReset(1'b1);
    cycle(0, 0, 0, 0, 3'd5, 0); chk(regRdData == 32'h2, "R2 strap captured", regRdData, 32'h2);
    cycle(0, 1, 0, 0, 3'd0, 0); chk(cpuEn == 1'b1, "R2 external tick used", {31'd0, cpuEn}, 1);
    cycle(1, 0, 0, 0, 3'd0, 0); chk(cpuEn == 1'b0, "R2 crystal ignored", {31'd0, cpuEn}, 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  ad;
      logic [31:0] wd;
      logic        we;
      if (n == 2000) doReset(logic'($urandom_range(0, 1)));
      ad = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 15) == 0);
      wd = $urandom;
      if (ad == 3'd1) begin
        wd = '0;
        for (int i = 0; i < 6; i++) wd[4*i +: 4] = 4'($urandom_range(0, 3));
      end
      cycle(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
            3'($urandom_range(0, 7)), we, ad, wd);
    end

    summary();
    $finish;
  end
endmodule